// File: doc/BRIEF.md
# Serial ADC Power-Mode and Conversion-Frame Controller

This block is the digital control core of a serial sampling converter. It runs on a fast system clock and watches two asynchronous pins from the host: the serial clock and the conversion strobe. Both pass through synchronizers, and only their rising edges matter. A conversion-strobe edge in the active state starts a conversion and opens a frame. The frame stays locked against new starts until a fixed number of serial-clock edges have been counted.

Power-down needs no extra pins. Conversion-strobe edges that arrive back to back, with no serial-clock edge between them, first drop the part into a light nap state and then into a deep sleep state. Any serial-clock edge brings it back to active. After a deep sleep the reference must settle again. A ready flag models that delay. A warning bit marks a conversion that started before the reference was ready.

The block has no data stream, so there is no valid/ready handshake. All pins are plain control and status levels or pulses. The host has no back-pressure path: the frame lockout is the only pacing rule. The serial-clock rate must stay below a quarter of the system clock.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset, pwr_mode is 0 (active), ref_ready is 1, and frame_busy, conv_start and acc_warn are all 0.
- R2: A conv_in rising edge while pwr_mode is active and frame_busy is 0 produces exactly one single-cycle conv_start pulse, within four system clocks, and frame_busy goes to 1.
- R3: While frame_busy is 1, conv_in rising edges start nothing. frame_busy stays 1 after 95 sck_in rising edges and clears on the 96th (FRAME_EDGES) edge counted after the start.
- R4: Two conv_in rising edges with no sck_in rising edge between them set pwr_mode to 1 (nap). In nap, ref_ready is unchanged.
- R5: Four conv_in rising edges with no sck_in rising edge between them set pwr_mode to 2 (sleep). More conv_in edges keep it in sleep. Sleep is left only for active.
- R6: Any sck_in rising edge returns pwr_mode to 0 from nap or sleep. The same edge restarts the back-to-back count from zero, so the pattern conv, sck, conv stays in active.
- R7: ref_ready is 0 from sleep entry onward. It returns to 1 exactly SETTLE_CYCLES system clocks after pwr_mode goes back to active from sleep.
- R8: At every conv_start pulse, acc_warn takes the inverse of ref_ready as it was at the start. It holds that value until the next start.
- R9: Only the rising edge of conv_in counts. A conv_in held high for many cycles starts one conversion and adds one to the back-to-back count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Asynchronous serial clock from the host |
| conv_in | input | 1 | Asynchronous conversion strobe from the host |
| conv_start | output | 1 | One-cycle pulse when a conversion starts |
| frame_busy | output | 1 | High while the frame lockout is counting serial-clock edges |
| pwr_mode | output | 2 | Power state: 0 active, 1 nap, 2 sleep |
| ref_ready | output | 1 | Reference settled after a sleep |
| acc_warn | output | 1 | Last conversion started before ref_ready was set |

## Verification
A wrong back-to-back count shows on pwr_mode two to four system clocks after the conv_in edge that should or should not have changed the state. A frame counter that is off by one moves the clearing of frame_busy to the 95th or the 97th serial-clock edge. Any conv_in edge near that boundary then gives an extra or a missing conv_start. A wrong settle timer moves the rise of ref_ready away from the exact cycle count, and a later conversion then reports the wrong acc_warn value.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_NAP    = 2'd1,
    PM_SLEEP  = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/in_sync_edge.sv
// Multi-stage synchronizer per channel with registered rising-edge detect.
module in_sync_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_ch
    logic [STAGES-1:0] pipe;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= '0;
        prev <= 1'b0;
      end else begin
        pipe <= {pipe[STAGES-2:0], async_in[b]};
        prev <= pipe[STAGES-1];
      end
    end
    assign rise_o[b] = pipe[STAGES-1] & ~prev;
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
// Counts strobe edges with no serial-clock edge between them and picks the power state.
module pwr_mode_fsm
  import adc_pwr_pkg::*;
#(
  parameter int NAP_EDGES   = 2,
  parameter int SLEEP_EDGES = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sck_rise,
  input  logic      conv_rise,
  output pwr_mode_e mode_o,
  output logic      enter_sleep_o,
  output logic      wake_sleep_o
);
  localparam int CW = $clog2(SLEEP_EDGES + 1);
  localparam logic [CW-1:0] SLP_N = CW'(SLEEP_EDGES);
  localparam logic [CW-1:0] NAP_N = CW'(NAP_EDGES);

  logic [CW-1:0] idle_cnt, base_cnt, next_cnt;
  pwr_mode_e     mode_q, mode_d;

  always_comb begin
    base_cnt = sck_rise ? '0 : idle_cnt;
    next_cnt = base_cnt;
    if (conv_rise && base_cnt < SLP_N) next_cnt = base_cnt + 1'b1;
  end

  always_comb begin
    mode_d = mode_q;
    if (sck_rise) begin
      mode_d = PM_ACTIVE;
    end else if (conv_rise) begin
      if (next_cnt >= SLP_N)      mode_d = PM_SLEEP;
      else if (next_cnt >= NAP_N) mode_d = PM_NAP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      mode_q   <= PM_ACTIVE;
    end else begin
      idle_cnt <= next_cnt;
      mode_q   <= mode_d;
    end
  end

  assign mode_o        = mode_q;
  assign enter_sleep_o = (mode_d == PM_SLEEP) && (mode_q != PM_SLEEP);
  assign wake_sleep_o  = (mode_q == PM_SLEEP) && sck_rise;
endmodule

// File: rtl/frame_lockout.sv
// Starts a frame on an accepted strobe edge and holds it for FRAME_EDGES serial-clock edges.
module frame_lockout #(
  parameter int FRAME_EDGES = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_rise,
  input  logic sck_rise,
  input  logic mode_active,
  output logic start_o,
  output logic busy_o
);
  localparam int FW = $clog2(FRAME_EDGES);
  localparam logic [FW-1:0] LAST = FW'(FRAME_EDGES - 1);

  logic [FW-1:0] edge_cnt;
  logic          busy_q;

  assign start_o = conv_rise && mode_active && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      edge_cnt <= '0;
    end else if (start_o) begin
      busy_q   <= 1'b1;
      edge_cnt <= '0;
    end else if (busy_q && sck_rise) begin
      if (edge_cnt == LAST) begin
        busy_q   <= 1'b0;
        edge_cnt <= '0;
      end else begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/ref_settle.sv
// Reference-ready model: low in sleep, high again SETTLE_CYCLES clocks after waking.
module ref_settle #(
  parameter int SETTLE_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_sleep,
  input  logic wake,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] tick;
  logic          settling, ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b1;
      settling <= 1'b0;
      tick     <= '0;
    end else if (enter_sleep) begin
      ready_q  <= 1'b0;
      settling <= 1'b0;
      tick     <= '0;
    end else if (wake) begin
      ready_q  <= 1'b0;
      settling <= 1'b1;
      tick     <= '0;
    end else if (settling) begin
      if (tick == LAST) begin
        ready_q  <= 1'b1;
        settling <= 1'b0;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int FRAME_EDGES   = 96,
  parameter int NAP_EDGES     = 2,
  parameter int SLEEP_EDGES   = 4,
  parameter int SETTLE_CYCLES = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_in,
  input  logic       conv_in,
  output logic       conv_start,
  output logic       frame_busy,
  output logic [1:0] pwr_mode,
  output logic       ref_ready,
  output logic       acc_warn
);
  logic [1:0] rise;
  logic       sck_rise, conv_rise;
  pwr_mode_e  mode;
  logic       enter_sleep, wake_sleep, start;
  logic       start_q, warn_q;

  in_sync_edge #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({conv_in, sck_in}),
    .rise_o   (rise)
  );
  assign sck_rise  = rise[0];
  assign conv_rise = rise[1];

  pwr_mode_fsm #(.NAP_EDGES(NAP_EDGES), .SLEEP_EDGES(SLEEP_EDGES)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_rise      (sck_rise),
    .conv_rise     (conv_rise),
    .mode_o        (mode),
    .enter_sleep_o (enter_sleep),
    .wake_sleep_o  (wake_sleep)
  );

  frame_lockout #(.FRAME_EDGES(FRAME_EDGES)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_rise   (conv_rise),
    .sck_rise    (sck_rise),
    .mode_active (mode == PM_ACTIVE),
    .start_o     (start),
    .busy_o      (frame_busy)
  );

  ref_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ref (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_sleep (enter_sleep),
    .wake        (wake_sleep),
    .ready_o     (ref_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      start_q <= start;
      if (start) warn_q <= !ref_ready;
    end
  end

  assign conv_start = start_q;
  assign acc_warn   = warn_q;
  assign pwr_mode   = mode;
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_start,
  input logic       frame_busy,
  input logic [1:0] pwr_mode,
  input logic       ref_ready,
  input logic       acc_warn
);
  // R5
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'd3);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R2
  start_opens_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> frame_busy);

  // R3
  start_not_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(frame_busy));

  // R5
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_mode) == 2'd2) |-> (pwr_mode == 2'd2 || pwr_mode == 2'd0));

  // R7
  sleep_no_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd2) |-> !ref_ready);

  // R8
  warn_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (acc_warn == !$past(ref_ready)));

  // R8
  warn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |-> $stable(acc_warn));
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .frame_busy (frame_busy),
  .pwr_mode   (pwr_mode),
  .ref_ready  (ref_ready),
  .acc_warn   (acc_warn)
);

// File: tb/adc_pwr_ctrl_tb_top.sv
module adc_pwr_ctrl_tb_top;
  localparam int SETTLE = 2000;
  localparam int FRAME  = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck_in = 1'b0;
  logic conv_in = 1'b0;
  logic conv_start, frame_busy, ref_ready, acc_warn;
  logic [1:0] pwr_mode;

  int checks = 0;
  int failures = 0;
  int start_cnt = 0;
  int cycle = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_pwr_ctrl #(.SETTLE_CYCLES(SETTLE), .FRAME_EDGES(FRAME)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_in     (sck_in),
    .conv_in    (conv_in),
    .conv_start (conv_start),
    .frame_busy (frame_busy),
    .pwr_mode   (pwr_mode),
    .ref_ready  (ref_ready),
    .acc_warn   (acc_warn)
  );

  always @(negedge clk) begin
    if (!rst_n) start_cnt <= 0;
    else if (conv_start) start_cnt <= start_cnt + 1;
  end

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (cycle > 150000 && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cycle, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sck_in = 1'b0; conv_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck_in = 1'b1;
    repeat (4) @(negedge clk);
    sck_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic conv_pulse(input int high_len);
    conv_in = 1'b1;
    repeat (high_len) @(negedge clk);
    conv_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // op[6] 1=conv 0=sck, mode[5:4], busy[3], ready[2], starts[1:0]
  localparam logic [6:0] VEC [10] = '{
    7'b1_00_1_1_01, 7'b1_01_1_1_01, 7'b0_00_1_1_01, 7'b1_00_1_1_01,
    7'b1_01_1_1_01, 7'b1_01_1_1_01, 7'b1_10_1_0_01, 7'b1_10_1_0_01,
    7'b0_00_1_0_01, 7'b1_00_1_0_01
  };

  initial begin
    int n;
    int s0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 mode", pwr_mode, 0);
    chk("R1 ready", ref_ready, 1);
    chk("R1 busy", frame_busy, 0);
    chk("R1 start", conv_start, 0);
    chk("R1 warn", acc_warn, 0);

    // Table walk: R2 R4 R5 R6 R7
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][6]) conv_pulse(4); else sck_pulse();
      chk($sformatf("R4 R5 R6 mode v%0d", i), pwr_mode, int'(VEC[i][5:4]));
      chk($sformatf("R3 busy v%0d", i), frame_busy, int'(VEC[i][3]));
      chk($sformatf("R7 ready v%0d", i), ref_ready, int'(VEC[i][2]));
      chk($sformatf("R2 starts v%0d", i), start_cnt, int'(VEC[i][1:0]));
    end

    // R3 lockout boundary 95 vs 96
    do_reset();
    conv_pulse(4);
    chk("R2 start count", start_cnt, 1);
    repeat (FRAME - 1) sck_pulse();
    chk("R3 busy after 95", frame_busy, 1);
    conv_pulse(4);
    chk("R3 no start at 95", start_cnt, 1);
    sck_pulse();
    chk("R3 busy after 96", frame_busy, 0);
    chk("R6 mode active", pwr_mode, 0);
    conv_pulse(4);
    chk("R3 start after 96", start_cnt, 2);

    // R9 long high strobe: one start, count one
    do_reset();
    conv_pulse(60);
    chk("R9 one start", start_cnt, 1);
    chk("R9 still active", pwr_mode, 0);
    conv_pulse(4);
    chk("R9 nap on second edge", pwr_mode, 1);

    // R7 exact settle delay
    do_reset();
    repeat (4) conv_pulse(4);
    chk("R5 sleep", pwr_mode, 2);
    chk("R7 ready low in sleep", ref_ready, 0);
    sck_in = 1'b1;
    for (int i = 0; i < 20 && pwr_mode != 0; i++) @(negedge clk);
    chk("R6 wake", pwr_mode, 0);
    n = 0;
    for (int i = 0; i < 3 * SETTLE && !ref_ready; i++) begin
      @(negedge clk);
      n++;
    end
    chk("R7 settle cycles", n, SETTLE);
    sck_in = 1'b0;
    repeat (4) @(negedge clk);

    // R8 early-conversion warning
    do_reset();
    conv_pulse(4);
    chk("R8 warn clear when ready", acc_warn, 0);
    repeat (3) conv_pulse(4);
    chk("R5 sleep again", pwr_mode, 2);
    repeat (FRAME) sck_pulse();
    chk("R3 frame done", frame_busy, 0);
    chk("R7 not yet ready", ref_ready, 0);
    s0 = start_cnt;
    conv_pulse(4);
    chk("R8 start before ready", start_cnt, s0 + 1);
    chk("R8 warn set", acc_warn, 1);
    for (int i = 0; i < 3 * SETTLE && !ref_ready; i++) @(negedge clk);
    chk("R7 ready later", ref_ready, 1);
    chk("R8 warn held", acc_warn, 1);
    repeat (FRAME) sck_pulse();
    conv_pulse(4);
    chk("R8 start after ready", start_cnt, s0 + 2);
    chk("R8 warn cleared", acc_warn, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule